// File: doc/BRIEF.md
# Receive FIFO Write Gate with Abort and Error Blocking

This block sits between a receive MAC that delivers one byte per cycle and a receive FIFO whose storage is organised as 32-bit words. It packs the byte stream into words, drives the FIFO write port (enable, address, data) and decides which packet data may enter the FIFO at all. A packet's first byte carries a start strobe and its last byte an end strobe. The block keeps two pointers. One is the write address. The other is a commit pointer that marks the end of the last complete packet, and the FIFO's read side may consume storage only up to that pointer.

Two conditions close the gate. An abort request drops the packet in progress by moving the write address back to the commit pointer. Writes then stay closed until a new start strobe arrives, and the block reopens them with no outside help. A receive error drops the packet in the same way, but it also locks the gate. The lock is released only by a clear pulse, and after that the next start strobe reopens writes. A configuration bit turns the abort request off entirely. A second configuration bit appends a status word after every accepted packet. That word always occupies a fresh word address of its own. The block emits a one-cycle drop pulse for every packet it discards.

Top module: `rx_fifo_wgate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fifo_we` and `pkt_drop` are 0, and `fifo_commit` and the first write address are both 0.
- R2: Accepted bytes are packed little-endian: the k-th byte of a word (k = 0..3 within the word) lands in bits [8k+7:8k]. A full word is written one cycle after its fourth byte is presented. A packet's words go to consecutive addresses that begin at the commit pointer.
- R3: The last word of a packet is written one cycle after the end-strobe byte is presented. Byte lanes above the last byte are 0.
- R4: With `cfg_stat_en`=1, a status word is written one cycle after the packet's last data word, at the next address. Its bits [15:0] hold the packet length in bytes and bits [31:16] are 0. This applies even when the length is a multiple of 4. The input must stay idle for at least one cycle after an end-strobe byte.
- R5: `fifo_commit` stays unchanged while a packet is being written. It moves to one past the packet's final word (the status word when enabled) in the same cycle that word is written.
- R6: If `rx_abort`=1 while a packet is in progress and `cfg_abort_off`=0, the byte presented in that cycle is dropped and `pkt_drop` is high for exactly one cycle, one cycle later. No further data of that packet is written, and the next accepted packet starts writing at the commit address.
- R7: After an abort, bytes without a start strobe are ignored. The next start-strobe byte is accepted and begins a new packet.
- R8: With `cfg_abort_off`=1, `rx_abort` has no effect: the packet is written completely and `pkt_drop` stays 0.
- R9: `rx_err`=1 in any cycle locks the gate. A packet in progress is discarded with a `pkt_drop` pulse. While locked, no data is written, start strobes included.
- R10: A pulse on `err_clr` (with `rx_err`=0) releases the lock. The first start-strobe byte presented after the clear cycle begins a packet that is written normally.
- R11: `rx_abort` or `rx_err` outside a packet produces no `pkt_drop`. `rx_abort` while locked does not release the lock. `err_clr` while unlocked has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_abort_off | input | 1 | 1 = ignore `rx_abort` |
| cfg_stat_en | input | 1 | 1 = append a status word after each packet |
| rx_vld | input | 1 | Byte valid |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive error, locks the gate |
| rx_abort | input | 1 | Drop the packet in progress |
| err_clr | input | 1 | Releases the error lock |
| fifo_we | output | 1 | FIFO word write enable |
| fifo_waddr | output | ADDR_W (6) | FIFO word write address |
| fifo_wdata | output | 32 | FIFO word write data |
| fifo_commit | output | ADDR_W (6) | One past the last word of the last complete packet |
| pkt_drop | output | 1 | One-cycle pulse per discarded packet |

## Verification
Each byte takes effect at the clock edge that follows the cycle in which it is presented. A data word therefore appears on the write port one cycle after its completing byte, and a status word two cycles after the end strobe. A drop pulse appears one cycle after the abort or error cycle. The bench drives inputs on the falling edge and records the write port and the drop pulse on the falling edge. Each record carries a cycle stamp from a counter advanced on the rising edge. Every check compares that stamp with the cycle in which the causing input was driven, plus exactly the expected latency. Counts of writes and drops are read only after enough idle cycles that nothing can still be in flight.

// File: rtl/rx_gate_pkg.sv
// Shared types for the receive FIFO write gate.
package rx_gate_pkg;
    // Gate state: waiting for a start strobe, inside a packet, or locked by an error.
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_PKT  = 2'd1,
        GS_ERR  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/rx_gate_fsm.sv
// Gate state machine: decides per cycle whether the presented byte is taken
// and whether the packet in progress is discarded.
// Assumes abort_req is already masked by configuration. An error outranks an
// abort, which outranks data. A start strobe inside a packet is treated as data.
module rx_gate_fsm
    import rx_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic byte_sop,
    input  logic byte_eop,
    input  logic abort_req,
    input  logic err_req,
    input  logic clr_req,
    output logic take,
    output logic drop
);
    gate_state_e state_q, state_d;

    // Next-state, accept and discard decisions.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                if (err_req) begin
                    state_d = GS_ERR;
                end else if (!abort_req && byte_vld && byte_sop) begin
                    take    = 1'b1;
                    state_d = byte_eop ? GS_IDLE : GS_PKT;
                end
            end
            GS_PKT: begin
                if (err_req) begin
                    drop    = 1'b1;
                    state_d = GS_ERR;
                end else if (abort_req) begin
                    drop    = 1'b1;
                    state_d = GS_IDLE;
                end else if (byte_vld) begin
                    take = 1'b1;
                    if (byte_eop) state_d = GS_IDLE;
                end
            end
            GS_ERR: begin
                if (!err_req && clr_req) state_d = GS_IDLE;
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GS_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rx_word_packer.sv
// Packs accepted bytes little-endian into words and counts the packet length.
// Assumes flush and take are never both high. The accumulator is zero whenever
// a word is started, so unused upper lanes of a final word read as zero.
module rx_word_packer #(
    parameter int BYTES  = 4,
    parameter int LEN_W  = 16,
    localparam int WORD_W = 8 * BYTES,
    localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic              sop,
    input  logic              eop,
    input  logic [7:0]        data,
    output logic              word_fire,
    output logic              word_last,
    output logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  pkt_len
);
    logic [BYTES-1:0][7:0] acc_q, merged;
    logic [LANE_W-1:0]     lane_q;
    logic [LEN_W-1:0]      len_q;

    // Merge the new byte into its lane and decide whether the word is complete.
    always_comb begin
        merged         = acc_q;
        merged[lane_q] = data;
        word           = merged;
        word_fire      = take && (eop || lane_q == LANE_W'(BYTES - 1));
        word_last      = take && eop;
        pkt_len        = (sop ? '0 : len_q) + 1'b1;
    end

    // Accumulator, lane index and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_q  <= '0;
            lane_q <= '0;
            len_q  <= '0;
        end else if (take) begin
            len_q <= pkt_len;
            if (word_fire) begin
                acc_q  <= '0;
                lane_q <= '0;
            end else begin
                acc_q  <= merged;
                lane_q <= lane_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_wr_port.sv
// Registers the FIFO write port, owns the write and commit pointers, rolls the
// write pointer back on a discard and appends the optional status word.
// Assumes at least one idle input cycle after a packet end, so a status write
// never coincides with a data word.
module rx_wr_port #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_fire,
    input  logic              word_last,
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              flush,
    input  logic              stat_en,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] commit
);
    logic [ADDR_W-1:0] ptr_q;
    logic              stat_pend_q;
    logic [LEN_W-1:0]  stat_len_q;

    // Write issue, pointer rollback, commit update and status append.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we          <= 1'b0;
            waddr       <= '0;
            wdata       <= '0;
            commit      <= '0;
            ptr_q       <= '0;
            stat_pend_q <= 1'b0;
            stat_len_q  <= '0;
        end else begin
            we <= 1'b0;
            if (flush) begin
                ptr_q <= commit;
            end else if (word_fire) begin
                we    <= 1'b1;
                waddr <= ptr_q;
                wdata <= word;
                ptr_q <= ptr_q + 1'b1;
                if (word_last) begin
                    if (stat_en) begin
                        stat_pend_q <= 1'b1;
                        stat_len_q  <= pkt_len;
                    end else begin
                        commit <= ptr_q + 1'b1;
                    end
                end
            end else if (stat_pend_q) begin
                we          <= 1'b1;
                waddr       <= ptr_q;
                wdata       <= WORD_W'(stat_len_q);
                ptr_q       <= ptr_q + 1'b1;
                commit      <= ptr_q + 1'b1;
                stat_pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_fifo_wgate.sv
// Receive FIFO write gate: packs the byte stream into FIFO words and blocks or
// discards packet data on abort and error conditions.
// Assumes a well-formed stream (start strobe on the first byte, end strobe on
// the last) and at least one idle cycle after each end strobe.
module rx_fifo_wgate #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 16,
    parameter int BYTES  = 4,
    localparam int WORD_W = 8 * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_abort_off,
    input  logic              cfg_stat_en,
    input  logic              rx_vld,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_byte,
    input  logic              rx_err,
    input  logic              rx_abort,
    input  logic              err_clr,
    output logic              fifo_we,
    output logic [ADDR_W-1:0] fifo_waddr,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic [ADDR_W-1:0] fifo_commit,
    output logic              pkt_drop
);
    logic              take, drop, abort_req;
    logic              word_fire, word_last;
    logic [WORD_W-1:0] word;
    logic [LEN_W-1:0]  pkt_len;

    assign abort_req = rx_abort && !cfg_abort_off;

    rx_gate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (rx_vld),
        .byte_sop  (rx_sop),
        .byte_eop  (rx_eop),
        .abort_req (abort_req),
        .err_req   (rx_err),
        .clr_req   (err_clr),
        .take      (take),
        .drop      (drop)
    );

    rx_word_packer #(.BYTES(BYTES), .LEN_W(LEN_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .flush     (drop),
        .sop       (rx_sop),
        .eop       (rx_eop),
        .data      (rx_byte),
        .word_fire (word_fire),
        .word_last (word_last),
        .word      (word),
        .pkt_len   (pkt_len)
    );

    rx_wr_port #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_fire (word_fire),
        .word_last (word_last),
        .word      (word),
        .pkt_len   (pkt_len),
        .flush     (drop),
        .stat_en   (cfg_stat_en),
        .we        (fifo_we),
        .waddr     (fifo_waddr),
        .wdata     (fifo_wdata),
        .commit    (fifo_commit)
    );

    // Registered one-cycle discard pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_drop <= 1'b0;
        else        pkt_drop <= drop;
    end
endmodule

// File: rtl/rx_fifo_wgate_chk.sv
// Property checker for the receive FIFO write gate, bound to the top module.
// It tracks the error lock from the ports alone.
module rx_fifo_wgate_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_abort_off,
    input logic              rx_vld,
    input logic              rx_eop,
    input logic              rx_err,
    input logic              err_clr,
    input logic              fifo_we,
    input logic [ADDR_W-1:0] fifo_waddr,
    input logic [ADDR_W-1:0] fifo_commit,
    input logic              pkt_drop
);
    logic lock_q;

    // Error lock as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (rx_err)  lock_q <= 1'b1;
        else if (err_clr) lock_q <= 1'b0;
    end

    AST_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_eop) |=> !rx_vld); // R4
    AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_we && $past(fifo_we)) |-> fifo_waddr == ADDR_W'($past(fifo_waddr) + 1'b1)); // R2
    AST_COMMIT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_commit) |-> fifo_we); // R5
    AST_COMMIT_PAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_commit) |-> fifo_commit == ADDR_W'(fifo_waddr + 1'b1)); // R5
    AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |=> !pkt_drop); // R6
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |-> !fifo_we); // R6
    AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_abort_off && !rx_err) |=> !pkt_drop); // R8
    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && $past(lock_q)) |-> !fifo_we); // R9
endmodule

bind rx_fifo_wgate rx_fifo_wgate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_abort_off (cfg_abort_off),
    .rx_vld        (rx_vld),
    .rx_eop        (rx_eop),
    .rx_err        (rx_err),
    .err_clr       (err_clr),
    .fifo_we       (fifo_we),
    .fifo_waddr    (fifo_waddr),
    .fifo_commit   (fifo_commit),
    .pkt_drop      (pkt_drop)
);

// File: tb/rx_fifo_wgate_bench.sv
`timescale 1ns/1ps
// Directed bench for the receive FIFO write gate: one task per scenario.
module rx_fifo_wgate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_abort_off = 1'b0, cfg_stat_en = 1'b0;
    logic        rx_vld = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_err = 1'b0, rx_abort = 1'b0, err_clr = 1'b0;
    logic        fifo_we, pkt_drop;
    logic [5:0]  fifo_waddr, fifo_commit;
    logic [31:0] fifo_wdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int wn = 0, dn = 0, c_eop = 0, c_w0 = 0, c_last = 0;
    logic [5:0]  wa [64];
    logic [5:0]  wc [64];
    logic [31:0] wd [64];
    int          ws [64];
    int          ds [64];

    rx_fifo_wgate u_rx_fifo_wgate (
        .clk(clk), .rst_n(rst_n), .cfg_abort_off(cfg_abort_off), .cfg_stat_en(cfg_stat_en),
        .rx_vld(rx_vld), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_byte(rx_byte),
        .rx_err(rx_err), .rx_abort(rx_abort), .err_clr(err_clr),
        .fifo_we(fifo_we), .fifo_waddr(fifo_waddr), .fifo_wdata(fifo_wdata),
        .fifo_commit(fifo_commit), .pkt_drop(pkt_drop)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record the write port and drop pulses on the falling edge.
    always @(negedge clk) begin
        if (rst_n && fifo_we && wn < 64) begin
            wa[wn] = fifo_waddr; wd[wn] = fifo_wdata; wc[wn] = fifo_commit; ws[wn] = cyc;
            wn = wn + 1;
        end
        if (rst_n && pkt_drop && dn < 64) begin
            ds[dn] = cyc;
            dn = dn + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, s, e, input logic [7:0] d, input logic ab, er, cl);
        @(negedge clk);
        rx_vld = v; rx_sop = s; rx_eop = e; rx_byte = d;
        rx_abort = ab; rx_err = er; err_clr = cl;
        c_last = cyc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            step(1'b1, i == 0, i == n - 1, base + 8'(i), 1'b0, 1'b0, 1'b0);
            if (i == 3)     c_w0  = c_last;
            if (i == n - 1) c_eop = c_last;
        end
        idle(4);
    endtask

    task automatic t_reset();
        chk("R1 we in reset", 32'(fifo_we), 0);
        chk("R1 drop in reset", 32'(pkt_drop), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 we after reset", 32'(fifo_we), 0);
        chk("R1 commit after reset", 32'(fifo_commit), 0);
        chk("R1 drop after reset", 32'(pkt_drop), 0);
    endtask

    task automatic t_full_words();
        int w0 = wn;
        send_pkt(8, 8'h10);
        chk("R2 word count", 32'(wn - w0), 2);
        chk("R2 first addr", 32'(wa[w0]), 0);
        chk("R2 first data", wd[w0], 32'h13121110);
        chk("R2 first timing", 32'(ws[w0]), 32'(c_w0 + 1));
        chk("R2 second addr", 32'(wa[w0+1]), 1);
        chk("R2 second data", wd[w0+1], 32'h17161514);
        chk("R5 commit mid packet", 32'(wc[w0]), 0);
        chk("R5 commit at end", 32'(wc[w0+1]), 2);
    endtask

    task automatic t_partial();
        int w0 = wn;
        send_pkt(6, 8'h20);
        chk("R3 word count", 32'(wn - w0), 2);
        chk("R2 start at commit", 32'(wa[w0]), 2);
        chk("R3 partial data", wd[w0+1], 32'h00002524);
        chk("R3 partial timing", 32'(ws[w0+1]), 32'(c_eop + 1));
        chk("R5 commit", 32'(fifo_commit), 4);
    endtask

    task automatic t_status();
        int w0 = wn;
        cfg_stat_en = 1'b1;
        send_pkt(5, 8'h30);
        chk("R4 word count", 32'(wn - w0), 3);
        chk("R4 last data", wd[w0+1], 32'h00000034);
        chk("R4 status addr", 32'(wa[w0+2]), 6);
        chk("R4 status value", wd[w0+2], 32'h00000005);
        chk("R4 status timing", 32'(ws[w0+2]), 32'(c_eop + 2));
        chk("R5 commit before status", 32'(wc[w0+1]), 4);
        chk("R5 commit with status", 32'(wc[w0+2]), 7);
        w0 = wn;
        send_pkt(8, 8'h40);
        chk("R4 aligned count", 32'(wn - w0), 3);
        chk("R4 aligned status", wd[w0+2], 32'h00000008);
        chk("R4 aligned status addr", 32'(wa[w0+2]), 9);
        chk("R4 aligned timing", 32'(ws[w0+2]), 32'(c_eop + 2));
        cfg_stat_en = 1'b0;
    endtask

    task automatic t_abort();
        int w0 = wn, d0 = dn, c_ab;
        for (int i = 0; i < 5; i++) step(1'b1, i == 0, 1'b0, 8'h50 + 8'(i), 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0);
        c_ab = c_last;
        idle(4);
        chk("R6 one drop", 32'(dn - d0), 1);
        chk("R6 drop timing", 32'(ds[d0]), 32'(c_ab + 1));
        chk("R6 no write after abort", 32'(wn - w0), 1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, i == 2, 8'h58 + 8'(i), 1'b0, 1'b0, 1'b0);
        idle(4);
        chk("R7 stray bytes ignored", 32'(wn - w0), 1);
        send_pkt(4, 8'h60);
        chk("R7 new packet written", 32'(wn - w0), 2);
        chk("R6 rollback addr", 32'(wa[w0+1]), 10);
        chk("R6 new data", wd[w0+1], 32'h63626160);
        chk("R6 commit", 32'(fifo_commit), 11);
    endtask

    task automatic t_abort_off();
        int w0 = wn, d0 = dn;
        cfg_abort_off = 1'b1;
        step(1'b1, 1'b1, 1'b0, 8'h70, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h71, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h72, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 8'h73, 1'b0, 1'b0, 1'b0);
        idle(4);
        chk("R8 no drop", 32'(dn - d0), 0);
        chk("R8 word written", 32'(wn - w0), 1);
        chk("R8 data", wd[w0], 32'h73727170);
        chk("R8 commit", 32'(fifo_commit), 12);
        cfg_abort_off = 1'b0;
    endtask

    task automatic t_error();
        int w0 = wn, d0 = dn, c_er;
        step(1'b1, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        c_er = c_last;
        idle(4);
        chk("R9 drop on error", 32'(dn - d0), 1);
        chk("R9 drop timing", 32'(ds[d0]), 32'(c_er + 1));
        send_pkt(4, 8'h90);
        chk("R9 blocked while locked", 32'(wn - w0), 0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        idle(2);
        send_pkt(4, 8'h94);
        chk("R11 abort keeps lock", 32'(wn - w0), 0);
        chk("R11 abort while locked no drop", 32'(dn - d0), 1);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle(1);
        send_pkt(4, 8'hA0);
        chk("R10 write after clear", 32'(wn - w0), 1);
        chk("R10 addr", 32'(wa[w0]), 12);
        chk("R10 data", wd[w0], 32'hA3A2A1A0);
    endtask

    task automatic t_idle_ctrl();
        int w0 = wn, d0 = dn;
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle(3);
        chk("R11 idle abort no drop", 32'(dn - d0), 0);
        send_pkt(2, 8'hB0);
        chk("R11 clear unlocked no effect", wd[w0], 32'h0000B1B0);
        chk("R11 addr", 32'(wa[w0]), 13);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R11 idle error no drop", 32'(dn - d0), 0);
        send_pkt(2, 8'hB4);
        chk("R9 idle error locks", 32'(wn - w0), 1);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        idle(1);
        send_pkt(1, 8'hC0);
        chk("R10 single byte packet", wd[w0+1], 32'h000000C0);
        chk("R3 single byte timing", 32'(ws[w0+1]), 32'(c_eop + 1));
        chk("R5 commit", 32'(fifo_commit), 15);
    endtask

    initial begin
        idle(3);
        t_reset();
        idle(2);
        t_full_words();
        t_partial();
        t_status();
        t_abort();
        t_abort_off();
        t_error();
        t_idle_ctrl();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule